// File: doc/BRIEF.md
# Masked Vector Gather-Scatter Unit

This block moves one sixteen-lane vector of 32-bit elements between a vector register and a local data memory. Each lane has its own address, which is formed from a shared base address plus that lane's entry in an index vector, scaled by the element size. A per-lane mask picks the lanes that take part. On a gather (load), the active lanes read memory. Narrow 8-bit and 16-bit elements are widened to 32 bits, with sign or zero extension. Lanes whose mask bit is clear keep the value they had in the destination vector, which the command supplies. On a scatter (store), only the active lanes write, and each write touches only the bytes of its element.

The command side is a valid/ready handshake. `cmd_ready` is high only while the unit is idle, so a command held valid during an operation waits and is not taken. The block walks the lanes in ascending order, one lane slot per clock, for 16 slots. A masked-off lane uses its slot without making a memory access. The memory port is a single port with combinational read data. A one-cycle `done` pulse follows the last slot. The loaded vector on `res_data` then stays stable until the next command is accepted.

Top module: `vgs_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `done` and `mem_req` are 0.
- R2: A lane's byte address is base + index × size, where size is 1, 2 or 4 for `cmd_fmt[1:0]` = 0, 1, 2 (the value 3 acts as 2). The address bits below the element size are forced to zero. Memory is little-endian: the byte at address offset k of a word sits on bits 8k+7..8k, and `mem_be` bit k enables it.
- R3: If a command is accepted at clock edge E, lane i owns the cycle that follows edge E+i. `mem_req` is high in that cycle exactly when mask bit i is set.
- R4: With the 32-bit format, a gather returns each active lane's memory word unchanged on `res_data` bits 32i+31..32i.
- R5: With the 8-bit format, a loaded byte is sign-extended when `cmd_fmt[2]` is 1 and zero-extended when it is 0.
- R6: With the 16-bit format, a loaded halfword is sign-extended when `cmd_fmt[2]` is 1 and zero-extended when it is 0.
- R7: On a gather, every lane whose mask bit is clear returns its `cmd_dest` value.
- R8: A scatter writes only the active lanes, and only the bytes of each element. All other memory bytes keep their values.
- R9: When active scatter lanes share an address, the highest-numbered of them leaves its value in memory.
- R10: `done` is high for exactly one cycle: the cycle after edge E+16. At that point `cmd_ready` is high again. `res_data` holds its value while no command is accepted.
- R11: `cmd_ready` is low from acceptance until `done`. A `cmd_valid` raised in that window has no effect on memory or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken when valid |
| cmd_store | input | 1 | 1 = scatter, 0 = gather |
| cmd_fmt | input | 3 | [1:0] element size code, [2] sign-extend on load |
| cmd_base | input | 16 | Base byte address |
| cmd_index | input | 192 | 16 lane indices of 12 bits, lane 0 in the low bits |
| cmd_mask | input | 16 | Lane enable, bit i for lane i |
| cmd_wdata | input | 512 | Scatter data, lane i at bits 32i+31..32i |
| cmd_dest | input | 512 | Previous destination vector for masked-off gather lanes |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the element |
| mem_be | output | 4 | Byte enables within the addressed word |
| mem_wdata | output | 32 | Write data, element replicated across the word |
| mem_rdata | input | 32 | Word read combinationally at `mem_addr` |
| res_data | output | 512 | Gathered vector |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a command offered while an operation is still in progress. The bench raises `cmd_valid` partway through a scatter, with a conflicting payload, and drops it again before `done`. It then confirms that the memory holds only the first scatter's effect. A second hard case is a scatter whose active lanes alias one address. The bench builds it with an index vector that repeats a single value under a sparse mask, so the lane-ordering rule decides the final word.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic       store;
    logic       sext;
    logic [1:0] size;
  } vgs_mode_t;
endpackage

// File: rtl/vgs_addr_gen.sv
module vgs_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] addr
);
  import vgs_pkg::*;
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] sum;
  logic [1:0]        low_keep;

  always_comb begin
    scaled = ADDR_W'(idx);
    unique case (size)
      SZ_BYTE: low_keep = 2'b11;
      SZ_HALF: begin scaled = scaled << 1; low_keep = 2'b10; end
      default: begin scaled = scaled << 2; low_keep = 2'b00; end
    endcase
    sum  = base + scaled;
    addr = sum & {{(ADDR_W-2){1'b1}}, low_keep};
  end
endmodule

// File: rtl/vgs_load_ext.sv
module vgs_load_ext #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          word,
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]             size,
  input  logic                   sext,
  output logic [DW-1:0]          elem
);
  import vgs_pkg::*;
  logic [DW-1:0] shifted;

  always_comb begin
    shifted = word >> {off, 3'b000};
    unique case (size)
      SZ_BYTE: elem = {{(DW-8){sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: elem = {{(DW-16){sext & shifted[15]}}, shifted[15:0]};
      default: elem = word;
    endcase
  end
endmodule

// File: rtl/vgs_store_pack.sv
module vgs_store_pack #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]           data,
  input  logic [$clog2(DW/8)-1:0] off,
  input  logic [1:0]              size,
  output logic [DW-1:0]           wdata,
  output logic [DW/8-1:0]         be
);
  import vgs_pkg::*;
  localparam int NB   = DW / 8;
  localparam int OFFW = $clog2(NB);

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        wdata = {NB{data[7:0]}};
        be    = NB'(1) << off;
      end
      SZ_HALF: begin
        wdata = {(NB/2){data[15:0]}};
        be    = NB'(3) << {off[OFFW-1:1], 1'b0};
      end
      default: begin
        wdata = data;
        be    = {NB{1'b1}};
      end
    endcase
  end
endmodule

// File: rtl/vgs_lane_seq.sv
module vgs_lane_seq #(
  parameter int LANES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic [$clog2(LANES)-1:0] lane,
  output logic                     done
);
  localparam int LW = $clog2(LANES);
  localparam logic [LW-1:0] LAST = LW'(LANES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lane <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        lane <= '0;
      end else if (busy) begin
        if (lane == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          lane <= '0;
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vgs_unit.sv
module vgs_unit #(
  parameter int LANES  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_store,
  input  logic [2:0]              cmd_fmt,
  input  logic [ADDR_W-1:0]       cmd_base,
  input  logic [LANES*IDX_W-1:0]  cmd_index,
  input  logic [LANES-1:0]        cmd_mask,
  input  logic [LANES*DW-1:0]     cmd_wdata,
  input  logic [LANES*DW-1:0]     cmd_dest,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DW/8-1:0]         mem_be,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  output logic [LANES*DW-1:0]     res_data,
  output logic                    done
);
  import vgs_pkg::*;
  localparam int NB   = DW / 8;
  localparam int OFFW = $clog2(NB);
  localparam int LW   = $clog2(LANES);

  vgs_mode_t          mode_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LANES-1:0]   mask_q;
  logic [IDX_W-1:0]   idx_q  [LANES];
  logic [DW-1:0]      wdat_q [LANES];
  logic [DW-1:0]      res_q  [LANES];

  logic               busy;
  logic [LW-1:0]      lane;
  logic               accept;
  logic [ADDR_W-1:0]  lane_addr;
  logic [DW-1:0]      load_elem;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  vgs_lane_seq #(.LANES(LANES)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .busy (busy),
    .lane (lane),
    .done (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (accept) begin
      mode_q <= '{store: cmd_store, sext: cmd_fmt[2], size: cmd_fmt[1:0]};
      base_q <= cmd_base;
      mask_q <= cmd_mask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        wdat_q[g] <= '0;
        res_q[g]  <= '0;
      end else if (accept) begin
        idx_q[g]  <= cmd_index[g*IDX_W +: IDX_W];
        wdat_q[g] <= cmd_wdata[g*DW +: DW];
        res_q[g]  <= cmd_dest[g*DW +: DW];
      end else if (busy && lane == LW'(g) && mask_q[g] && !mode_q.store) begin
        res_q[g]  <= load_elem;
      end
    end
    assign res_data[g*DW +: DW] = res_q[g];
  end

  vgs_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q),
    .idx (idx_q[lane]),
    .size(mode_q.size),
    .addr(lane_addr)
  );

  vgs_load_ext #(.DW(DW)) u_ext (
    .word(mem_rdata),
    .off (lane_addr[OFFW-1:0]),
    .size(mode_q.size),
    .sext(mode_q.sext),
    .elem(load_elem)
  );

  vgs_store_pack #(.DW(DW)) u_pack (
    .data (wdat_q[lane]),
    .off  (lane_addr[OFFW-1:0]),
    .size (mode_q.size),
    .wdata(mem_wdata),
    .be   (mem_be)
  );

  assign mem_req  = busy && mask_q[lane];
  assign mem_we   = mem_req && mode_q.store;
  assign mem_addr = lane_addr;
endmodule

// File: rtl/vgs_chk.sv
module vgs_chk #(
  parameter int NB = 4,
  parameter int RW = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [NB-1:0] mem_be,
  input logic          done,
  input logic [RW-1:0] res_data
);
  // R3 / R11: memory is only touched while an operation owns the unit
  p_idle_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  // R8: writes only happen as part of a request
  p_write_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  // R2: an access enables one, two or four bytes
  p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: the unit is idle again when done is seen
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R10: result holds while no command is accepted
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(res_data));
endmodule

bind vgs_unit vgs_chk #(.NB(DW/8), .RW(LANES*DW)) u_vgs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .done     (done),
  .res_data (res_data)
);

// File: tb/tb_vgs_unit.sv
module tb_vgs_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_store = 1'b0;
  logic [2:0]    cmd_fmt = '0;
  logic [15:0]   cmd_base = '0;
  logic [191:0]  cmd_index = '0;
  logic [15:0]   cmd_mask = '0;
  logic [511:0]  cmd_wdata = '0;
  logic [511:0]  cmd_dest = '0;
  logic          mem_req, mem_we;
  logic [15:0]   mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [511:0]  res_data;
  logic          done;

  logic [31:0] mem     [0:255];
  logic [31:0] exp_mem [0:255];
  logic [11:0] idx  [LANES];
  logic [31:0] wd   [LANES];
  logic [31:0] dst  [LANES];

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vgs_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_fmt(cmd_fmt), .cmd_base(cmd_base),
    .cmd_index(cmd_index), .cmd_mask(cmd_mask), .cmd_wdata(cmd_wdata),
    .cmd_dest(cmd_dest), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .res_data(res_data), .done(done)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  initial begin
    for (int c = 0; c < 60000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h9C, 8'h80 | b, b, 8'hF0 ^ b};
  endfunction

  function automatic logic [15:0] m_addr(logic [15:0] base, logic [11:0] ix,
                                         logic [2:0] f);
    int sh = (f[1:0] == 2'd0) ? 0 : (f[1:0] == 2'd1) ? 1 : 2;
    logic [15:0] a = base + ({4'b0, ix} << sh);
    return a & ~((16'd1 << sh) - 16'd1);
  endfunction

  function automatic logic [31:0] m_load(logic [15:0] a, logic [2:0] f);
    logic [31:0] w = mem[a[9:2]];
    logic [31:0] s = w >> {a[1:0], 3'b000};
    case (f[1:0])
      2'd0: return f[2] ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
      2'd1: return f[2] ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic m_store(logic [15:0] a, logic [2:0] f, logic [31:0] d);
    int n = (f[1:0] == 2'd0) ? 1 : (f[1:0] == 2'd1) ? 2 : 4;
    for (int b = 0; b < n; b++) begin
      logic [15:0] ab = a + 16'(b);
      exp_mem[ab[9:2]][8*ab[1:0] +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  // Issue one command, check lane timing, access addresses and done timing.
  task automatic run_op(input string tag, input bit st, input logic [2:0] f,
                        input logic [15:0] base, input logic [15:0] mask,
                        input bit poke);
    bit timing_ok = 1;
    bit addr_ok = 1;
    @(negedge clk);
    cmd_store = st; cmd_fmt = f; cmd_base = base; cmd_mask = mask;
    for (int i = 0; i < LANES; i++) begin
      cmd_index[12*i +: 12] = idx[i];
      cmd_wdata[32*i +: 32] = wd[i];
      cmd_dest[32*i +: 32]  = dst[i];
    end
    cmd_valid = 1'b1;
    check(cmd_ready == 1'b1, {tag, " R11 ready when idle"}, 32'(cmd_ready), 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 1; k <= 17; k++) begin
      if (k > 1) @(negedge clk);
      if (poke && k == 3) begin
        cmd_valid = 1'b1; cmd_store = 1'b1; cmd_fmt = 3'd2; cmd_mask = 16'hFFFF;
        cmd_base = 16'h0000; cmd_wdata = {16{32'hBADBAD00}};
      end
      if (poke && k == 10) cmd_valid = 1'b0;
      if (k <= 16) begin
        int ln = k - 1;
        if (cmd_ready !== 1'b0 || done !== 1'b0) timing_ok = 0;
        if (mem_req !== mask[ln]) addr_ok = 0;
        if (mask[ln] && mem_addr !== m_addr(base, idx[ln], f)) addr_ok = 0;
      end else begin
        if (done !== 1'b1 || cmd_ready !== 1'b1) timing_ok = 0;
      end
    end
    check(addr_ok, {tag, " R2 R3 lane order and addresses"}, 32'(mem_addr), 32'd0);
    check(timing_ok, {tag, " R10 R11 busy window and done slot"}, 32'(done), 32'd1);
    @(negedge clk);
    check(done == 1'b0, {tag, " R10 done is one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic check_load(input string tag, input string req, input logic [2:0] f,
                            input logic [15:0] base, input logic [15:0] mask);
    bit ok = 1;
    logic [31:0] a0 = '0, e0 = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] e = mask[i] ? m_load(m_addr(base, idx[i], f), f) : dst[i];
      if (res_data[32*i +: 32] !== e && ok) begin
        ok = 0; a0 = res_data[32*i +: 32]; e0 = e;
      end
    end
    check(ok, {tag, " ", req}, a0, e0);
  endtask

  task automatic check_mem(input string tag, input string req);
    bit ok = 1;
    logic [31:0] a0 = '0, e0 = '0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i] && ok) begin ok = 0; a0 = mem[i]; e0 = exp_mem[i]; end
    check(ok, {tag, " ", req}, a0, e0);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'd1);
    check(done == 1'b0, "R1 done low after reset", 32'(done), 32'd0);
    check(mem_req == 1'b0, "R1 no access after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_gather32();
    for (int i = 0; i < LANES; i++) begin idx[i] = 12'((i * 7) % 32); dst[i] = 0; end
    run_op("gather32", 0, 3'b010, 16'h0100, 16'hFFFF, 0);
    check_load("gather32", "R4 word gather", 3'b010, 16'h0100, 16'hFFFF);
  endtask

  task automatic t_gather8();
    for (int i = 0; i < LANES; i++) begin idx[i] = 12'(i * 5 + 1); dst[i] = 0; end
    run_op("gather8s", 0, 3'b100, 16'h0040, 16'hFFFF, 0);
    check_load("gather8s", "R5 byte sign extension", 3'b100, 16'h0040, 16'hFFFF);
    run_op("gather8z", 0, 3'b000, 16'h0040, 16'hFFFF, 0);
    check_load("gather8z", "R5 byte zero extension", 3'b000, 16'h0040, 16'hFFFF);
  endtask

  task automatic t_gather16();
    for (int i = 0; i < LANES; i++) begin idx[i] = 12'(i * 3); dst[i] = 0; end
    run_op("gather16s", 0, 3'b101, 16'h0082, 16'hFFFF, 0);
    check_load("gather16s", "R6 half sign extension", 3'b101, 16'h0082, 16'hFFFF);
    run_op("gather16z", 0, 3'b001, 16'h0082, 16'hFFFF, 0);
    check_load("gather16z", "R6 half zero extension", 3'b001, 16'h0082, 16'hFFFF);
  endtask

  task automatic t_masked_load();
    for (int i = 0; i < LANES; i++) begin idx[i] = 12'(i); dst[i] = 32'hDEAD0000 | i; end
    run_op("mload", 0, 3'b010, 16'h0000, 16'hA5C3, 0);
    check_load("mload", "R7 masked lanes keep destination", 3'b010, 16'h0000, 16'hA5C3);
    repeat (3) @(negedge clk);
    check_load("mload", "R10 result holds while idle", 3'b010, 16'h0000, 16'hA5C3);
  endtask

  task automatic t_scatter(input string tag, input logic [2:0] f, input logic [15:0] base,
                           input logic [15:0] mask, input int stride, input string req);
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < LANES; i++) begin
      idx[i] = 12'(i * stride); wd[i] = 32'hC0DE0000 + 32'(i * 32'h01010101);
      if (mask[i]) m_store(m_addr(base, idx[i], f), f, wd[i]);
    end
    run_op(tag, 1, f, base, mask, 0);
    check_mem(tag, req);
  endtask

  task automatic t_collision();
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < LANES; i++) begin idx[i] = 12'd5; wd[i] = 32'h11110000 + i; end
    exp_mem[(16'h0380 + 16'd20) >> 2] = wd[15];
    run_op("collide", 1, 3'b010, 16'h0380, 16'h8421, 0);
    check(mem[(16'h0380 + 16'd20) >> 2] == wd[15], "R9 highest lane wins",
          mem[(16'h0380 + 16'd20) >> 2], wd[15]);
    check_mem("collide", "R9 collision memory image");
  endtask

  task automatic t_busy_ignore();
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < LANES; i++) begin
      idx[i] = 12'(i * 2); wd[i] = 32'h5A5A0000 + i;
      m_store(m_addr(16'h0200, idx[i], 3'b010), 3'b010, wd[i]);
    end
    run_op("busy", 1, 3'b010, 16'h0200, 16'hFFFF, 1);
    check_mem("busy", "R11 command offered while busy is ignored");
    check(cmd_ready == 1'b1, "R11 idle after ignored command", 32'(cmd_ready), 32'd1);
  endtask

  initial begin
    fill_mem();
    for (int i = 0; i < LANES; i++) begin idx[i] = 0; wd[i] = 0; dst[i] = 0; end
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gather32();
    t_gather8();
    t_gather16();
    t_masked_load();
    t_scatter("scatter32", 3'b010, 16'h0200, 16'h0F0F, 1, "R8 masked word scatter");
    t_scatter("scatter8", 3'b000, 16'h0301, 16'hFFFF, 3, "R8 byte scatter keeps neighbours");
    t_scatter("scatter16", 3'b001, 16'h0342, 16'h007E, 3, "R8 half scatter keeps neighbours");
    t_collision();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule